// File: doc/BRIEF.md
# Pattern Bank Mapper with Tile-Fetch Latches

This block turns a 13-bit pattern-table address from the picture unit into a bank number for the pattern memory. Software loads eight 16-bit bank registers one byte at a time. A two-bit page-size field selects 8, 4, 2 or 1 KiB pages, and so sets which registers cover which part of the address space. An outer AND mask and an OR base are then applied to the chosen register. Both are shifted right to match the page size, so one pair of outer values serves every granularity.

With 4 KiB pages the block can also run in latch mode. Each 4 KiB half has its own latch. The latch flips between two registers when the picture unit fetches one of two marker tiles in that half. A separate protect input gates write strobes toward pattern RAM.

All control pins are plain levels and strobes. There is no data stream in this block, so there is no valid/ready handshake and no back-pressure. A register write is accepted on every cycle in which its strobe is high.

Top module: `chrmap_bank_unit`

## Requirements
- R1: After reset all eight bank registers and both latches are zero. With an AND mask of 0xFFFF and an OR base of 0, every address then maps to bank 0.
- R2: A register write with `reg_hi`=0 replaces bits 7:0 of the register chosen by `reg_idx` and leaves bits 15:8 unchanged.
- R3: A register write with `reg_hi`=1 replaces bits 15:8 of the chosen register and leaves bits 7:0 unchanged.
- R4: With `page_mode`=00 (8 KiB), every address maps to (reg0 & (and>>3)) | (or>>3).
- R5: With `page_mode`=01 (4 KiB) and latch mode off, address bit 12 = 0 uses reg0 and bit 12 = 1 uses reg4. The mask and base are shifted right by 2.
- R6: With `page_mode`=10 (2 KiB), address bits 12:11 select reg 0, 2, 4 or 6. The mask and base are shifted right by 1.
- R7: With `page_mode`=11 (1 KiB), address bits 12:10 select reg 0 to 7. The mask and base are used unshifted.
- R8: With latch mode on and `page_mode`=01, each half uses register (latch | base), where base is 0 for the lower half and 4 for the upper half and the latch value is 0 or 2. In the other page modes latch mode has no effect.
- R9: A fetch (`ppu_rd`=1) at offset 0xFD8 within a half sets that half's latch to 0. A fetch at offset 0xFE8 sets it to 2. The other half's latch and all other fetches leave the latches unchanged. The new latch value takes effect from the next cycle.
- R10: `chr_ram_we` follows `ppu_wr` while `ram_protect`=0 and stays 0 while `ram_protect`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bank register byte write strobe |
| reg_idx | input | 3 | Register index |
| reg_hi | input | 1 | 1 = write bits 15:8, 0 = write bits 7:0 |
| reg_data | input | 8 | Write data byte |
| page_mode | input | 2 | 00=8 KiB, 01=4 KiB, 10=2 KiB, 11=1 KiB |
| latch_mode | input | 1 | Enables latch switching in 4 KiB mode |
| ram_protect | input | 1 | Blocks pattern RAM writes |
| outer_and | input | 16 | Outer AND mask (1 KiB units) |
| outer_or | input | 16 | Outer OR base (1 KiB units) |
| ppu_addr | input | 13 | Pattern-table address |
| ppu_rd | input | 1 | Fetch strobe used for latch updates |
| ppu_wr | input | 1 | Pattern RAM write request |
| bank_out | output | 16 | Selected bank number |
| chr_ram_we | output | 1 | Gated pattern RAM write enable |

## Verification
`bank_out` and `chr_ram_we` are combinational, so they are due in the same cycle as the address, mode and mask inputs that drive them. A register write or a latch-setting fetch shows up only after the next rising edge. The driver task changes inputs on a falling edge and queues the expected value. The monitor compares the outputs a quarter period later. Each write or fetch task spans a full cycle before the next probe is queued, so every expected value already includes the register update it depends on.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned REG_COUNT = 1 << REG_IDX_W;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HALF_OFS_W = 12;

  typedef enum logic [1:0] {
    PG_8K = 2'b00,
    PG_4K = 2'b01,
    PG_2K = 2'b10,
    PG_1K = 2'b11
  } page_mode_e;

  localparam logic [HALF_OFS_W-1:0] MARK_TO_ZERO = 12'hFD8;
  localparam logic [HALF_OFS_W-1:0] MARK_TO_TWO  = 12'hFE8;
endpackage

// File: rtl/chrmap_regfile.sv
module chrmap_regfile
  import chrmap_pkg::*;
#(
  parameter int unsigned BANK_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [REG_IDX_W-1:0]                 wr_idx,
  input  logic                                 wr_hi,
  input  logic [BYTE_W-1:0]                    wr_data,
  output logic [REG_COUNT-1:0][BANK_W-1:0]     regs_o
);
  localparam int unsigned HI_W = BANK_W - BYTE_W;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
      end else if (wr_en && (wr_idx == REG_IDX_W'(g))) begin
        if (wr_hi) regs_o[g][BANK_W-1:BYTE_W] <= wr_data[HI_W-1:0];
        else       regs_o[g][BYTE_W-1:0]      <= wr_data;
      end
    end
  end

  // R2: low byte replaced, high byte kept
  a_r2_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> regs_o[$past(wr_idx)][BYTE_W-1:0] == $past(wr_data));
  a_r2_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> regs_o[$past(wr_idx)][BANK_W-1:BYTE_W] ==
                          $past(regs_o[wr_idx][BANK_W-1:BYTE_W]));
  // R3: high byte replaced, low byte kept
  a_r3_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> regs_o[$past(wr_idx)][BYTE_W-1:0] ==
                         $past(regs_o[wr_idx][BYTE_W-1:0]));
endmodule

// File: rtl/chrmap_tile_latch.sv
module chrmap_tile_latch
  import chrmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        sel_two   // bit h set: latch of half h holds 2
);
  localparam int unsigned OFS_W = ADDR_W - 1;

  logic [OFS_W-1:0] ofs;
  logic             half;
  assign ofs  = addr[OFS_W-1:0];
  assign half = addr[ADDR_W-1];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_two[h] <= 1'b0;
      end else if (fetch && (half == 1'(h))) begin
        if (ofs == OFS_W'(MARK_TO_ZERO))     sel_two[h] <= 1'b0;
        else if (ofs == OFS_W'(MARK_TO_TWO)) sel_two[h] <= 1'b1;
      end
    end
  end

  // R9: marker fetches set the latch of their own half
  a_r9_mark_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && ofs == OFS_W'(MARK_TO_ZERO)) |=> !sel_two[$past(half)]);
  a_r9_mark_two: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && ofs == OFS_W'(MARK_TO_TWO)) |=> sel_two[$past(half)]);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> $stable(sel_two));
endmodule

// File: rtl/chrmap_bank_select.sv
module chrmap_bank_select
  import chrmap_pkg::*;
#(
  parameter int unsigned BANK_W = 16,
  parameter int unsigned ADDR_W = 13
) (
  input  logic [REG_COUNT-1:0][BANK_W-1:0] regs,
  input  page_mode_e                       mode,
  input  logic                             latch_mode,
  input  logic [1:0]                       sel_two,
  input  logic [BANK_W-1:0]                and_mask,
  input  logic [BANK_W-1:0]                or_base,
  input  logic [ADDR_W-1:0]                addr,
  output logic [BANK_W-1:0]                bank
);
  logic [REG_IDX_W-1:0] page;
  logic [REG_IDX_W-1:0] idx;
  logic [1:0]           shift;

  assign page = addr[ADDR_W-1 -: REG_IDX_W];

  always_comb begin
    unique case (mode)
      PG_8K: begin idx = '0;                                          shift = 2'd3; end
      PG_4K: begin idx = {page[2], latch_mode & sel_two[page[2]], 1'b0}; shift = 2'd2; end
      PG_2K: begin idx = {page[2:1], 1'b0};                           shift = 2'd1; end
      default: begin idx = page;                                      shift = 2'd0; end
    endcase
  end

  assign bank = (regs[idx] & (and_mask >> shift)) | (or_base >> shift);
endmodule

// File: rtl/chrmap_bank_unit.sv
module chrmap_bank_unit
  import chrmap_pkg::*;
#(
  parameter int unsigned BANK_W = 16,
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_idx,
  input  logic              reg_hi,
  input  logic [7:0]        reg_data,
  input  logic [1:0]        page_mode,
  input  logic              latch_mode,
  input  logic              ram_protect,
  input  logic [BANK_W-1:0] outer_and,
  input  logic [BANK_W-1:0] outer_or,
  input  logic [ADDR_W-1:0] ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  output logic [BANK_W-1:0] bank_out,
  output logic              chr_ram_we
);
  logic [REG_COUNT-1:0][BANK_W-1:0] regs;
  logic [1:0]                       sel_two;

  chrmap_regfile #(.BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_idx),
    .wr_hi(reg_hi), .wr_data(reg_data), .regs_o(regs)
  );

  chrmap_tile_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .fetch(ppu_rd), .addr(ppu_addr), .sel_two(sel_two)
  );

  chrmap_bank_select #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_sel (
    .regs(regs), .mode(page_mode_e'(page_mode)), .latch_mode(latch_mode),
    .sel_two(sel_two), .and_mask(outer_and), .or_base(outer_or),
    .addr(ppu_addr), .bank(bank_out)
  );

  assign chr_ram_we = ppu_wr & ~ram_protect;

  // R10: protected RAM never sees a write enable
  a_r10_protect: assert property (@(posedge clk) disable iff (!rst_n)
    ram_protect |-> !chr_ram_we);
  // R8: latch mode outside 4 KiB pages must not move the bank
  a_r8_latch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode != 2'b01 && $stable(page_mode) && $stable(ppu_addr) && $stable(outer_and)
     && $stable(outer_or) && !$past(reg_wr) && $stable(latch_mode)) |-> $stable(bank_out));
endmodule

// File: tb/chrmap_bank_unit_test.sv
module chrmap_bank_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic        reg_hi = 1'b0;
  logic [7:0]  reg_data = '0;
  logic [1:0]  page_mode = 2'b11;
  logic        latch_mode = 1'b0;
  logic        ram_protect = 1'b0;
  logic [15:0] outer_and = 16'hFFFF;
  logic [15:0] outer_or = 16'h0000;
  logic [12:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic        ppu_wr = 1'b0;
  logic [15:0] bank_out;
  logic        chr_ram_we;

  chrmap_bank_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_hi(reg_hi),
    .reg_data(reg_data), .page_mode(page_mode), .latch_mode(latch_mode),
    .ram_protect(ram_protect), .outer_and(outer_and), .outer_or(outer_or),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .bank_out(bank_out), .chr_ram_we(chr_ram_we)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] shadow [8];
  int          lat [2];

  function automatic logic [16:0] model(input logic [12:0] a, input logic w);
    int idx;
    int sh;
    case (page_mode)
      2'b00: begin idx = 0; sh = 3; end
      2'b01: begin idx = a[12] * 4 + (latch_mode ? lat[a[12]] : 0); sh = 2; end
      2'b10: begin idx = int'(a[12:11]) * 2; sh = 1; end
      default: begin idx = int'(a[12:10]); sh = 0; end
    endcase
    return {w & ~ram_protect, (shadow[idx] & (outer_and >> sh)) | (outer_or >> sh)};
  endfunction

  task automatic probe(input logic [12:0] a, input logic w, input string tag);
    @(negedge clk);
    ppu_addr = a; ppu_rd = 1'b0; ppu_wr = w;
    exp_q.push_back(model(a, w));
    tag_q.push_back(tag);
  endtask

  task automatic wr(input int i, input bit hi, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'(i); reg_hi = hi; reg_data = d;
    if (hi) shadow[i][15:8] = d; else shadow[i][7:0] = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic fetch(input logic [12:0] a);
    @(negedge clk);
    ppu_addr = a; ppu_rd = 1'b1; ppu_wr = 1'b0;
    if (a[11:0] == 12'hFD8) lat[a[12]] = 0;
    else if (a[11:0] == 12'hFE8) lat[a[12]] = 2;
    @(negedge clk);
    ppu_rd = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] pm, input bit lm, input bit prot,
                     input logic [15:0] am, input logic [15:0] om);
    @(negedge clk);
    page_mode = pm; latch_mode = lm; ram_protect = prot; outer_and = am; outer_or = om;
  endtask

  // monitor: compares queued expectations a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (exp_q.size() > 0) begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({chr_ram_we, bank_out} !== e) begin
          errors++;
          $display("FAIL %s: got we=%0b bank=%h expected we=%0b bank=%h",
                   t, chr_ram_we, bank_out, e[16], e[15:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    lat[0] = 0; lat[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    probe(13'h0000, 1'b0, "R1 reset low page");
    probe(13'h1C00, 1'b0, "R1 reset high page");

    // R2 / R3: byte writes into reg0, seen in 1 KiB mode
    wr(0, 1'b0, 8'h5A);
    probe(13'h0000, 1'b0, "R2 low byte write");
    wr(0, 1'b1, 8'h12);
    probe(13'h0000, 1'b0, "R3 high byte write keeps low");
    wr(0, 1'b0, 8'h33);
    probe(13'h0000, 1'b0, "R2 low byte write keeps high");

    for (int i = 1; i < 8; i++) begin
      wr(i, 1'b0, 8'(8'h40 + i * 3));
      wr(i, 1'b1, 8'(i * 17));
    end

    // R7: 1 KiB pages
    for (int p = 0; p < 8; p++) probe(13'(p * 1024 + 5), 1'b0, "R7 1KiB page");
    cfg(2'b11, 1'b0, 1'b0, 16'h00F3, 16'h0A00);
    probe(13'h0C10, 1'b0, "R7 1KiB with masks");

    // R6: 2 KiB pages
    cfg(2'b10, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
    for (int p = 0; p < 4; p++) probe(13'(p * 2048 + 1024), 1'b0, "R6 2KiB page");
    cfg(2'b10, 1'b0, 1'b0, 16'h01F0, 16'h0600);
    probe(13'h1800, 1'b0, "R6 2KiB with masks");

    // R5: 4 KiB pages
    cfg(2'b01, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
    probe(13'h0FFF, 1'b0, "R5 4KiB lower half");
    probe(13'h1000, 1'b0, "R5 4KiB upper half");
    cfg(2'b01, 1'b0, 1'b0, 16'h03F0, 16'h0C00);
    probe(13'h1800, 1'b0, "R5 4KiB with masks");

    // R4: 8 KiB page
    cfg(2'b00, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
    probe(13'h1FFF, 1'b0, "R4 8KiB");
    cfg(2'b00, 1'b0, 1'b0, 16'h07F8, 16'h4000);
    probe(13'h0400, 1'b0, "R4 8KiB with masks");

    // R8 / R9: latch mode
    cfg(2'b01, 1'b1, 1'b0, 16'hFFFF, 16'h0000);
    probe(13'h0100, 1'b0, "R8 latch reset lower");
    fetch(13'h0FE8);
    probe(13'h0100, 1'b0, "R9 lower latch to two");
    probe(13'h1100, 1'b0, "R9 upper latch untouched");
    fetch(13'h1FE8);
    probe(13'h1100, 1'b0, "R9 upper latch to two");
    fetch(13'h0FE0);
    probe(13'h0100, 1'b0, "R9 other fetch ignored");
    fetch(13'h0FD8);
    probe(13'h0100, 1'b0, "R9 lower latch to zero");
    probe(13'h1100, 1'b0, "R8 upper still on reg6");
    cfg(2'b10, 1'b1, 1'b0, 16'hFFFF, 16'h0000);
    probe(13'h1100, 1'b0, "R8 latch ignored in 2KiB");
    cfg(2'b01, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
    probe(13'h1100, 1'b0, "R8 latch mode off");

    // R10: write protect
    probe(13'h0000, 1'b1, "R10 write allowed");
    cfg(2'b01, 1'b0, 1'b1, 16'hFFFF, 16'h0000);
    probe(13'h0000, 1'b1, "R10 write blocked");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule